// File: doc/BRIEF.md
# Destination Address Filter with Setup-Image Loading

This block decides, for each received Ethernet frame, whether the frame's destination MAC address is one of sixteen stored addresses. The stored table is not written through registers. It is filled by streaming a fixed 192-byte setup image into the block one byte at a time. The image holds sixteen 12-byte slots, and each slot carries one address with every 16-bit half-word sent twice in a row.

Received frames arrive as a byte stream whose first byte is marked by a start-of-frame flag. The block gathers the first six bytes, compares them against all sixteen slots at once, and raises a one-cycle accept or reject pulse in the cycle after the sixth byte. Slots may repeat an address, and a slot of all-ones bytes lets broadcast frames through. A setup stream of the wrong length is discarded whole, so a truncated or overlong image can never leave a half-written table in use.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, frame_accept, frame_reject and setup_error are all 0.
- R2: Setup byte k (counted from 0 within a stream) belongs to slot k/12. Within a slot, the byte positions 0..11 carry address bytes 0,1,0,1,2,3,2,3,4,5,4,5, and address byte 0 is the one compared with the first byte of a frame. Only the copies at positions 0,1,4,5,8,9 are stored.
- R3: If a byte at position 2,3,6,7,10 or 11 differs from the stored first copy, setup_error goes to 1 and stays 1 until reset. The image is still installed if its length is correct, using the first copies.
- R4: An image is installed only when setup_last arrives on exactly the 192nd byte of a stream. A stream that ends earlier or later is dropped, and the previously installed table stays in force.
- R5: Exactly one of frame_accept or frame_reject is 1 for exactly one cycle, in the cycle after the rx_valid cycle that carries the sixth byte of a frame. The byte with rx_sof set is byte 1. Cycles with rx_valid low are not counted.
- R6: frame_accept is chosen when the six destination bytes equal the address in any slot; otherwise frame_reject is chosen. All slots are compared, and duplicate slots are allowed.
- R7: A slot whose six address bytes are all 0xFF makes frames sent to the broadcast address accepted. Without such a slot, broadcast frames are rejected.
- R8: Bytes after the sixth produce no further pulse. A byte with rx_sof restarts the count, and a frame cut short before its sixth byte produces no pulse.
- R9: Until a correctly sized image has been installed since reset, every frame is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | A setup byte is present |
| setup_data | input | 8 | Setup image byte |
| setup_last | input | 1 | Marks the final byte of a setup stream |
| rx_valid | input | 1 | A received-frame byte is present |
| rx_sof | input | 1 | Marks the first byte of a frame (valid only with rx_valid) |
| rx_data | input | 8 | Received-frame byte |
| frame_accept | output | 1 | One-cycle pulse: destination matched a slot |
| frame_reject | output | 1 | One-cycle pulse: destination matched no slot, or no table installed |
| setup_error | output | 1 | Sticky flag: a repeated half-word copy disagreed with its first copy |

## Verification
The assertions assume that rx_sof is only raised together with rx_valid, and that the setup and receive streams are otherwise independent and free of unknown values once reset is released. They also assume a new table is installed only between frame headers, so a decision never straddles a table change. The stimulus drives every input on the falling clock edge, raises rx_sof only with rx_valid, and waits for each image to settle before sending frames.

// File: rtl/daf_pkg.sv
// Package: shared constants and types for the destination address filter.
// Assumes six-byte MAC addresses and the twelve-byte doubled slot layout.
package daf_pkg;
    localparam int ADDR_BYTES  = 6;
    localparam int ENTRY_BYTES = 2 * ADDR_BYTES;

    // Byte 0 is the first byte seen on the wire.
    typedef logic [ADDR_BYTES-1:0][7:0] mac_t;
endpackage

// File: rtl/daf_setup_loader.sv
// Setup loader: decodes a streamed setup image into a shadow table.
// Keeps the first copy of each doubled half-word, flags disagreeing
// second copies, and emits a commit pulse the cycle after a stream that
// ended on exactly its last image byte.
// Assumes setup_last is only meaningful together with setup_valid.
module daf_setup_loader
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     setup_valid,
    input  logic [7:0]               setup_data,
    input  logic                     setup_last,
    output mac_t [ENTRIES-1:0]       shadow,
    output logic                     commit,
    output logic                     copy_err
);
    localparam int IMG = ENTRIES * ENTRY_BYTES;
    localparam int CW  = $clog2(IMG + 1);
    localparam int EW  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [CW-1:0] cnt;
    logic [3:0]    pos;
    logic [EW-1:0] ent;
    logic [2:0]    bidx;
    logic          in_range;

    // Address byte addressed by the current slot position.
    assign bidx     = {pos[3:2], pos[0]};
    assign in_range = (cnt < CW'(IMG));

    // Stream decode: store first copies, check second copies, track length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pos      <= '0;
            ent      <= '0;
            commit   <= 1'b0;
            copy_err <= 1'b0;
            shadow   <= '0;
        end else begin
            commit <= 1'b0;
            if (setup_valid) begin
                if (in_range) begin
                    if (!pos[1]) begin
                        shadow[ent][bidx] <= setup_data;
                    end else if (shadow[ent][bidx] != setup_data) begin
                        copy_err <= 1'b1;
                    end
                end
                if (setup_last) begin
                    commit <= (cnt == CW'(IMG - 1));
                    cnt    <= '0;
                    pos    <= '0;
                    ent    <= '0;
                end else begin
                    if (cnt != CW'(IMG)) begin
                        cnt <= cnt + 1'b1;
                    end
                    if (pos == 4'(ENTRY_BYTES - 1)) begin
                        pos <= '0;
                        ent <= ent + 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/daf_table.sv
// Active table: copies the shadow table on a commit pulse and records
// that a table has been installed since reset.
// Assumes commit is a single-cycle pulse from the loader.
module daf_table
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  mac_t [ENTRIES-1:0] image,
    output mac_t [ENTRIES-1:0] entries,
    output logic               loaded
);
    // Install the shadow image and mark the table usable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
            loaded  <= 1'b0;
        end else if (commit) begin
            entries <= image;
            loaded  <= 1'b1;
        end
    end
endmodule

// File: rtl/daf_matcher.sv
// Matcher: captures the first destination bytes of a frame and, on the
// sixth byte, compares against every slot in parallel. The decision is
// registered, so it appears the cycle after the sixth byte.
// Assumes rx_sof is only raised with rx_valid.
module daf_matcher
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sof,
    input  logic [7:0]         rx_data,
    input  mac_t [ENTRIES-1:0] entries,
    input  logic               loaded,
    output logic               frame_accept,
    output logic               frame_reject
);
    localparam int IW = $clog2(ADDR_BYTES + 1);

    logic [IW-1:0]                 idx;
    logic [IW-1:0]                 cur;
    logic [ADDR_BYTES-2:0][7:0]    dest;
    logic                          take;
    logic                          sixth;
    logic [ENTRIES-1:0]            hit;

    assign cur   = rx_sof ? '0 : idx;
    assign take  = rx_valid && (rx_sof || (idx < IW'(ADDR_BYTES)));
    assign sixth = take && (cur == IW'(ADDR_BYTES - 1));

    // One comparator per slot; the last byte comes straight from the input.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit[e] = (entries[e][ADDR_BYTES-1] == rx_data) &&
                        (entries[e][ADDR_BYTES-2:0] == dest);
    end

    // Header capture: count bytes since start of frame, keep early bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            dest <= '0;
        end else if (take) begin
            idx <= cur + 1'b1;
            if (cur < IW'(ADDR_BYTES - 1)) begin
                dest[cur] <= rx_data;
            end
        end
    end

    // Decision register: one pulse per frame header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_accept <= 1'b0;
            frame_reject <= 1'b0;
        end else begin
            frame_accept <= sixth && loaded && (|hit);
            frame_reject <= sixth && !(loaded && (|hit));
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
// Top level: perfect destination address filter loaded from a doubled
// setup image. Wires the loader, the active table and the matcher.
// Assumes independent setup and receive streams on one clock.
module dest_addr_filter
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_valid,
    input  logic [7:0] setup_data,
    input  logic       setup_last,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [7:0] rx_data,
    output logic       frame_accept,
    output logic       frame_reject,
    output logic       setup_error
);
    mac_t [ENTRIES-1:0] shadow_tbl;
    mac_t [ENTRIES-1:0] active_tbl;
    logic               commit;
    logic               table_loaded;

    daf_setup_loader #(.ENTRIES(ENTRIES)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_data  (setup_data),
        .setup_last  (setup_last),
        .shadow      (shadow_tbl),
        .commit      (commit),
        .copy_err    (setup_error)
    );

    daf_table #(.ENTRIES(ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .image   (shadow_tbl),
        .entries (active_tbl),
        .loaded  (table_loaded)
    );

    daf_matcher #(.ENTRIES(ENTRIES)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_data      (rx_data),
        .entries      (active_tbl),
        .loaded       (table_loaded),
        .frame_accept (frame_accept),
        .frame_reject (frame_reject)
    );
endmodule

// File: rtl/daf_checker.sv
// Checker: timing and ordering properties of the filter, observed from
// its ports and its table-installed flag. Keeps its own byte counters.
module daf_checker
    import daf_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic setup_valid,
    input logic setup_last,
    input logic rx_valid,
    input logic rx_sof,
    input logic frame_accept,
    input logic frame_reject,
    input logic setup_error,
    input logic table_loaded
);
    localparam int IMG = ENTRIES * ENTRY_BYTES;
    localparam int SW  = $clog2(IMG + 2) + 1;

    logic [2:0]    rcnt;
    logic [SW-1:0] scnt;
    logic          sixth_byte;
    logic          good_end;

    assign sixth_byte = rx_valid && !rx_sof && (rcnt == 3'(ADDR_BYTES - 1));
    assign good_end   = setup_valid && setup_last && (scnt == SW'(IMG - 1));

    // Independent count of frame bytes seen since start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        rcnt <= '0;
        else if (rx_valid) rcnt <= rx_sof ? 3'd1 : ((rcnt == 3'd7) ? rcnt : rcnt + 3'd1);
    end

    // Independent count of setup bytes in the current stream.
    always_ff @(posedge clk) begin
        if (!rst_n)                      scnt <= '0;
        else if (setup_valid && setup_last) scnt <= '0;
        else if (setup_valid && scnt != '1) scnt <= scnt + 1'b1;
    end

    // R5: never both decisions at once.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_accept && frame_reject));

    // R5 / R8: a decision appears exactly one cycle after a sixth byte.
    a_r5_decision_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_accept || frame_reject) == $past(sixth_byte));

    // R9: no acceptance without an installed table.
    a_r9_no_accept_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        frame_accept |-> table_loaded);

    // R3: the copy-mismatch flag is sticky.
    a_r3_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_error |=> setup_error);

    // R4: a table first becomes installed only after a correctly sized stream.
    a_r4_install_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(table_loaded) |-> $past(good_end, 2));
endmodule

bind dest_addr_filter daf_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup_valid  (setup_valid),
    .setup_last   (setup_last),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .frame_accept (frame_accept),
    .frame_reject (frame_reject),
    .setup_error  (setup_error),
    .table_loaded (table_loaded)
);

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       setup_valid = 1'b0;
    logic [7:0] setup_data = '0;
    logic       setup_last = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       frame_accept;
    logic       frame_reject;
    logic       setup_error;

    int n_checks = 0;
    int n_errors = 0;

    logic [47:0] tbl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    dest_addr_filter #(.ENTRIES(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_data(setup_data), .setup_last(setup_last),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .frame_accept(frame_accept), .frame_reject(frame_reject),
        .setup_error(setup_error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [47:0] addr_a(input int e);
        logic [7:0] b1, b2, b4, b5;
        b1 = 8'(8'h10 + e);
        b2 = 8'(8'hA0 ^ (e * 7));
        b4 = 8'(e * 5 + 1);
        b5 = 8'(8'hC0 + e);
        return {8'h02, b1, b2, 8'h33, b4, b5};
    endfunction

    function automatic logic [47:0] addr_b(input int e);
        return addr_a(e) ^ 48'h0000_0000_FF00;
    endfunction

    // Byte b of the image built from tbl, following the doubled layout.
    function automatic logic [7:0] img_byte(input int b);
        int e, p, idx;
        e   = (b / 12) % 16;
        p   = b % 12;
        idx = (p / 4) * 2 + (p % 2);
        return tbl[e][47 - 8*idx -: 8];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_image(input int nbytes, input int bad_pos);
        for (int b = 0; b < nbytes; b++) begin
            @(negedge clk);
            setup_valid = 1'b1;
            setup_data  = img_byte(b) ^ ((b == bad_pos) ? 8'h01 : 8'h00);
            setup_last  = (b == nbytes - 1);
        end
        @(negedge clk);
        setup_valid = 1'b0;
        setup_last  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Sends a header, checks the pulse one cycle after the sixth byte and
    // checks silence for the trailing bytes.
    task automatic send_frame(input logic [47:0] mac, input bit exp_acc,
                              input string req, input bit gaps, input int ntrail);
        for (int i = 0; i < 6; i++) begin
            if (gaps && i > 0) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_sof   = 1'b0;
            end
            @(negedge clk);
            check(!frame_accept && !frame_reject, {req, " early pulse"},
                  int'(frame_accept | frame_reject), 0);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_data  = mac[47 - 8*i -: 8];
        end
        @(negedge clk);
        rx_sof = 1'b0;
        if (ntrail > 0) begin
            rx_valid = 1'b1;
            rx_data  = 8'h55;
        end else begin
            rx_valid = 1'b0;
        end
        check(frame_accept == exp_acc && frame_reject == !exp_acc, req,
              int'({frame_accept, frame_reject}), int'({exp_acc, !exp_acc}));
        for (int t = 1; t <= ntrail; t++) begin
            @(negedge clk);
            rx_valid = (t < ntrail);
            rx_data  = 8'(8'h60 + t);
            check(!frame_accept && !frame_reject, {req, " R8 trailing"},
                  int'({frame_accept, frame_reject}), 0);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check(!frame_accept && !frame_reject, {req, " R5 single pulse"},
              int'({frame_accept, frame_reject}), 0);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", MAX_CYCLES, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!frame_accept && !frame_reject && !setup_error, "R1 reset outputs",
              int'({frame_accept, frame_reject, setup_error}), 0);

        // R9: nothing installed yet
        send_frame(addr_a(0), 1'b0, "R9 unloaded a0", 1'b0, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R9 unloaded broadcast", 1'b0, 0);

        // R2 / R6: install table A and sweep every slot and near miss
        for (int e = 0; e < 16; e++) tbl[e] = addr_a(e);
        send_image(192, -1);
        check(setup_error == 1'b0, "R3 clean image no error", int'(setup_error), 0);
        for (int e = 0; e < 16; e++) begin
            send_frame(addr_a(e), 1'b1, "R2 R6 slot hit", 1'b0, 0);
            for (int j = 0; j < 6; j++) begin
                logic [47:0] m;
                m = addr_a(e);
                m[47 - 8*j] = ~m[47 - 8*j];
                send_frame(m, 1'b0, "R6 near miss", 1'b0, 0);
            end
        end
        // R7: no all-ones slot yet
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, "R7 broadcast without slot", 1'b0, 0);
        // R5: idle gaps between bytes
        send_frame(addr_a(7), 1'b1, "R5 gaps hit", 1'b1, 0);
        send_frame(addr_b(7), 1'b0, "R5 gaps miss", 1'b1, 0);
        // R8: trailing bytes ignored
        send_frame(addr_a(9), 1'b1, "R8 trailing hit", 1'b0, 5);
        // R8: a cut-short frame then a restart
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_data  = addr_b(1)[47 - 8*i -: 8];
        end
        send_frame(addr_a(2), 1'b1, "R8 restart after short", 1'b0, 0);

        // R4: short and long images are dropped
        for (int e = 0; e < 16; e++) tbl[e] = addr_b(e);
        send_image(191, -1);
        send_frame(addr_a(0), 1'b1, "R4 short kept old", 1'b0, 0);
        send_frame(addr_b(0), 1'b0, "R4 short not installed", 1'b0, 0);
        send_image(193, -1);
        send_frame(addr_a(5), 1'b1, "R4 long kept old", 1'b0, 0);
        send_frame(addr_b(5), 1'b0, "R4 long not installed", 1'b0, 0);
        send_image(200, -1);
        send_frame(addr_b(15), 1'b0, "R4 overlong not installed", 1'b0, 0);

        // R6 / R7: duplicates and an all-ones slot
        tbl[14] = addr_b(0);
        tbl[15] = 48'hFFFF_FFFF_FFFF;
        send_image(192, -1);
        send_frame(48'hFFFF_FFFF_FFFF, 1'b1, "R7 broadcast slot", 1'b0, 0);
        send_frame(addr_b(0), 1'b1, "R6 duplicate slot", 1'b0, 0);
        send_frame(addr_b(13), 1'b1, "R6 table B hit", 1'b0, 0);
        send_frame(addr_a(3), 1'b0, "R4 table replaced", 1'b0, 0);
        send_frame(addr_b(15), 1'b0, "R6 overwritten slot", 1'b0, 0);

        // R3: second-copy mismatch in slot 3, first copy wins
        for (int e = 0; e < 16; e++) tbl[e] = addr_a(e);
        send_image(192, 3*12 + 2);
        check(setup_error == 1'b1, "R3 mismatch flagged", int'(setup_error), 1);
        send_frame(addr_a(3), 1'b1, "R3 first copy kept", 1'b0, 0);
        send_image(192, 5*12 + 11);
        send_frame(addr_a(5), 1'b1, "R3 last copy mismatch still installs", 1'b0, 0);
        send_image(192, -1);
        check(setup_error == 1'b1, "R3 sticky", int'(setup_error), 1);

        // R1 / R9: reset clears everything
        do_reset();
        @(negedge clk);
        check(setup_error == 1'b0, "R1 error cleared", int'(setup_error), 0);
        send_frame(addr_a(3), 1'b0, "R9 after reset", 1'b0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule